// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block handles the even parity signal of a PCI agent that can act as either initiator or target. Each cycle it looks at the 32-bit address/data bus, the 4-bit command/byte-enable bus, the kind of bus phase in progress and the agent's current role. From these it decides whether it must drive the parity line or check it.

When the agent owns the bus for that phase, the block drives the parity bit one clock after the bus values it covers. When another agent is driving, it compares the incoming parity bit, one clock later, against its own calculation. A data parity error produces a one-clock low pulse on the data-error output. An address parity error produces a one-clock enable on the open-drain system-error output instead.

While the block drives data parity, it also watches the shared data-error line for errors that the other agent reports. All three error kinds are held in sticky flags. The host clears each flag by writing one to it.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_out` equals the XOR of all 32 `ad` bits and all 4 `cbe` bits of the previous cycle, which makes the 37-bit group even.
- R2: `par_oe` is high in the cycle after a phase in which the agent drives parity. As master (`is_master`=1) that is an address phase (`phase`=01) or a write data phase (`phase`=11). As target it is a read data phase (`phase`=10). Idle (`phase`=00) never drives.
- R3: Parity is checked for a master read data phase, and for a target address phase or target write data phase. A mismatch on `par_in` in any other phase raises no error.
- R4: For a checked data phase in cycle N where `par_in` in cycle N+1 disagrees, `perr_n` is low in cycle N+2 only. Otherwise it is high.
- R5: For a checked address phase in cycle N where `par_in` in cycle N+1 disagrees, `serr_oe` is high in cycle N+2 only. `perr_n` stays high for that error.
- R6: `stat_dpe` rises in the same cycle as the `perr_n` pulse, and `stat_ape` rises in the same cycle as the `serr_oe` pulse. Both then stay set.
- R7: `stat_rpe` is set one cycle after a cycle N+2 in which `perr_in_n` is sampled low, where the agent drove parity in cycle N+1 for a data phase in cycle N.
- R8: A high bit in `clr` clears its flag at the next edge: bit 0 clears `stat_dpe`, bit 1 clears `stat_ape`, bit 2 clears `stat_rpe`. If the flag is being set in the same cycle, the set wins.
- R9: After reset, `par_oe`, `serr_oe` and all flags are 0, and `perr_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad | input | 32 | Address/data bus value this cycle |
| cbe | input | 4 | Command/byte-enable bus value this cycle |
| phase | input | 2 | 00 idle, 01 address, 10 read data, 11 write data |
| is_master | input | 1 | 1 when the agent is the initiator |
| par_in | input | 1 | Parity bit seen on the bus |
| perr_in_n | input | 1 | Data-error line seen on the bus, active low |
| clr | input | 3 | Write-one-to-clear pulses for the flags |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Enable for driving par_out |
| perr_n | output | 1 | Data parity error, active low |
| serr_oe | output | 1 | Pull-down enable for the system error line |
| stat_dpe | output | 1 | Sticky: data parity error detected |
| stat_ape | output | 1 | Sticky: address parity error detected |
| stat_rpe | output | 1 | Sticky: error reported by the other agent |

## Verification
The assertions assume that `phase` and `is_master` are valid every cycle, and that `par_in` in cycle N+1 belongs to the phase of cycle N. This means back-to-back phases are legal, but the two error pulses can never coincide, because an address phase and a data phase can never share a cycle. The stimulus is generated so that every cycle carries a fully defined phase code and role. Each injected parity fault is a deliberate flip of the correct parity of the previous cycle. The stimulus covers every combination of phase and role, the clear-versus-set collision, and long runs of random phases.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad,
  input  logic [3:0]  cbe,
  input  logic [1:0]  phase,
  input  logic        is_master,
  input  logic        par_in,
  input  logic        perr_in_n,
  input  logic [2:0]  clr,
  output logic        par_out,
  output logic        par_oe,
  output logic        perr_n,
  output logic        serr_oe,
  output logic        stat_dpe,
  output logic        stat_ape,
  output logic        stat_rpe
);

  localparam logic [1:0] PH_ADDR = 2'b01;
  localparam logic [1:0] PH_RD   = 2'b10;
  localparam logic [1:0] PH_WR   = 2'b11;

  logic drive_now, check_data_now, check_addr_now, is_data_now;
  logic chk_d1, chk_a1, dat1, drv_dat2;
  logic bad_data, bad_addr;

  assign is_data_now    = phase == PH_RD || phase == PH_WR;
  assign drive_now      = is_master ? (phase == PH_ADDR || phase == PH_WR) : (phase == PH_RD);
  assign check_data_now = is_master ? (phase == PH_RD) : (phase == PH_WR);
  assign check_addr_now = !is_master && phase == PH_ADDR;

  assign bad_data = chk_d1 && (par_in != par_out);
  assign bad_addr = chk_a1 && (par_in != par_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_out  <= 1'b0;
      par_oe   <= 1'b0;
      chk_d1   <= 1'b0;
      chk_a1   <= 1'b0;
      dat1     <= 1'b0;
      drv_dat2 <= 1'b0;
      perr_n   <= 1'b1;
      serr_oe  <= 1'b0;
      stat_dpe <= 1'b0;
      stat_ape <= 1'b0;
      stat_rpe <= 1'b0;
    end else begin
      par_out  <= ^{ad, cbe};
      par_oe   <= drive_now;
      chk_d1   <= check_data_now;
      chk_a1   <= check_addr_now;
      dat1     <= is_data_now;
      drv_dat2 <= par_oe && dat1;
      perr_n   <= !bad_data;
      serr_oe  <= bad_addr;
      stat_dpe <= (stat_dpe && !clr[0]) || bad_data;
      stat_ape <= (stat_ape && !clr[1]) || bad_addr;
      stat_rpe <= (stat_rpe && !clr[2]) || (drv_dat2 && !perr_in_n);
    end
  end

  assert_par_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> par_out == ^{$past(ad), $past(cbe)});

  assert_drive_role_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> $past(phase) != 2'b00);

  assert_perr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_n) |-> stat_dpe);

  assert_serr_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> perr_n && stat_ape);

  assert_sticky_dpe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_dpe && !clr[0] |=> stat_dpe);

  assert_sticky_ape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ape && !clr[1] |=> stat_ape);

  assert_sticky_rpe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rpe && !clr[2] |=> stat_rpe);

endmodule

// File: tb/pci_parity_unit_tb_top.sv
module pci_parity_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0] cbe = '0;
  logic [1:0] phase = '0;
  logic is_master = 1'b0, par_in = 1'b0, perr_in_n = 1'b1;
  logic [2:0] clr = '0;
  logic par_out, par_oe, perr_n, serr_oe, stat_dpe, stat_ape, stat_rpe;

  int total = 0, bad = 0;
  logic done = 1'b0;

  // reference state
  bit e_par, e_oe, e_perr_n = 1, e_serr, e_dpe, e_ape, e_rpe;
  bit h_chkd, h_chka, h_dat, h_drvd2;
  bit prev_par;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  pci_parity_unit dut_i (.clk, .rst_n, .ad, .cbe, .phase, .is_master, .par_in, .perr_in_n,
    .clr, .par_out, .par_oe, .perr_n, .serr_oe, .stat_dpe, .stat_ape, .stat_rpe);

  task automatic chk(input string req, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic model_edge();
    bit mis_d, mis_a, drv, chkd, chka;
    mis_d = h_chkd && (par_in != e_par);
    mis_a = h_chka && (par_in != e_par);
    e_perr_n = !mis_d;
    e_serr = mis_a;
    e_dpe = (e_dpe && !clr[0]) || mis_d;
    e_ape = (e_ape && !clr[1]) || mis_a;
    e_rpe = (e_rpe && !clr[2]) || (h_drvd2 && !perr_in_n);
    h_drvd2 = e_oe && h_dat;
    case (phase)
      2'b01: begin drv = is_master;  chkd = 0; chka = !is_master; end
      2'b10: begin drv = !is_master; chkd = is_master; chka = 0; end
      2'b11: begin drv = is_master;  chkd = !is_master; chka = 0; end
      default: begin drv = 0; chkd = 0; chka = 0; end
    endcase
    e_par = ^{ad, cbe};
    e_oe = drv;
    h_chkd = chkd;
    h_chka = chka;
    h_dat = phase[1];
  endtask

  task automatic cyc(input bit [31:0] a, input bit [3:0] c, input bit [1:0] ph,
                     input bit m, input bit flip, input bit pin_n, input bit [2:0] cl);
    ad = a; cbe = c; phase = ph; is_master = m;
    par_in = prev_par ^ flip; perr_in_n = pin_n; clr = cl;
    @(posedge clk);
    model_edge();
    prev_par = ^{a, c};
    #1;
    chk("R1 par_out", par_out, e_par);
    chk("R2 par_oe", par_oe, e_oe);
    chk("R3/R4 perr_n", perr_n, e_perr_n);
    chk("R3/R5 serr_oe", serr_oe, e_serr);
    chk("R6 stat_dpe", stat_dpe, e_dpe);
    chk("R6 stat_ape", stat_ape, e_ape);
    chk("R7 stat_rpe", stat_rpe, e_rpe);
  endtask

  initial begin
    #40000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 par_oe", par_oe, 0);
    chk("R9 perr_n", perr_n, 1);
    chk("R9 serr_oe", serr_oe, 0);
    chk("R9 flags", stat_dpe | stat_ape | stat_rpe, 0);
    rst_n = 1'b1;
    // R2 master address + write drive parity
    cyc(32'hDEAD_BEEF, 4'h7, 2'b01, 1, 0, 1, 0);
    cyc(32'h0000_0001, 4'h0, 2'b11, 1, 0, 1, 0);
    // R7 other agent reports error on that write
    cyc(32'h0, 4'h0, 2'b00, 1, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 1, 0, 0, 0);
    cyc(32'h0, 4'h0, 2'b00, 1, 0, 1, 0);
    // R3 mismatch on an unchecked phase (master write) raises nothing
    cyc(32'hFFFF_0000, 4'hF, 2'b11, 1, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 1, 1, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 1, 0, 1, 0);
    // R4 master read with bad parity
    cyc(32'h1357_9BDF, 4'h3, 2'b10, 1, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 1, 1, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 1, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 1, 0, 1, 0);
    // R5 target address error
    cyc(32'hA5A5_A5A5, 4'h6, 2'b01, 0, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b11, 0, 1, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 0, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 0, 0, 1, 0);
    // R8 clear all, then clear-vs-set collision on dpe
    cyc(32'h0, 4'h0, 2'b00, 0, 0, 1, 3'b111);
    cyc(32'h0000_00FF, 4'h1, 2'b11, 0, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 0, 1, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 0, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b11, 0, 0, 1, 0);
    cyc(32'h0, 4'h0, 2'b00, 0, 1, 1, 3'b001);
    cyc(32'h0, 4'h0, 2'b00, 0, 0, 1, 3'b001);
    cyc(32'h0, 4'h0, 2'b00, 0, 0, 1, 0);
    // random phases, roles, faults and clears
    for (int i = 0; i < 2000; i++) begin
      int unsigned r;
      r = rnd();
      cyc(rnd(), r[3:0], r[17:16], r[18], r[22:20] == 0, r[26:24] != 0, (r[30:28] == 0) ? 3'(rnd()) : 3'b000);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule